// File: doc/BRIEF.md
# Prescaled Master Period Timer

This block is a free-running up-counter with a programmable period and a 3-bit prescaler code. The counter value is kept in fine time units. At fine prescaler codes the counter takes several fine units per clock and its low bits carry no information. At coarse codes it advances one unit every one, two or four clocks. When the next step would carry the counter past the programmed period, the counter returns to zero and a one-cycle wrap pulse is raised.

A small register bus holds two registers, the counter and the period. `bus_sel` picks one of them. A write lands on the rising clock edge where `bus_wr` is high. The read data follows the selection without a clock. The counter accepts writes only while the timer is stopped. Period writes are clamped into the legal window for the current prescaler code.

Top module: `mpt_master_timer`

## Requirements
- R1: After a synchronous reset the counter reads 0x0000_0000, the period reads 0x0000_FFDF and `wrap_pulse` is low.
- R2: Bits 31:16 of the read data are always zero. The same bits of write data have no effect on either register.
- R3: A counter write (`bus_sel`=0) while `run_en` is 1 is ignored. The counting step of that edge still takes place.
- R4: For prescaler code c below 5, the lowest 5-c counter bits read as zero and drop written data. For codes 5 to 7, all 16 bits are kept.
- R5: For prescaler code c below 5, the running counter advances by 2^(5-c) on every clock.
- R6: For prescaler codes 5 to 7, the running counter advances by 1 once every 2^(c-5) clocks. The first step comes on the 2^(c-5)-th enabled edge.
- R7: When counter plus step exceeds the period, that step loads 0 instead. In the following cycle `wrap_pulse` is high for exactly one cycle while the counter reads 0.
- R8: A period write above 0xFFDF stores 0xFFDF. The period changes only on a period write.
- R9: A period write below the minimum stores the minimum. The minimum is 3*2^(5-c) for prescaler code c below 5 (0x60 at code 0), and 3 for codes 5 to 7.
- R10: A counter written above the period while stopped goes to 0 on the first enabled step and raises the wrap pulse.
- R11: While `run_en` is 0, the counter keeps its value unless it is written, and no wrap pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| run_en | input | 1 | Timer runs while high |
| psc_code | input | 3 | Prescaler code 0..7 |
| bus_wr | input | 1 | Register write strobe |
| bus_sel | input | 1 | Register select: 0 counter, 1 period |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the selected register |
| wrap_pulse | output | 1 | One-cycle pulse after the counter wraps to zero |

## Verification
A counter write and a counting step can arrive on the same clock edge. The bench starts the timer, presents a counter write on the second enabled edge, stops it and reads the counter back. The value must match two plain steps from the start value, with no trace of the written data. A wrap can also arrive on the step that follows a counter written above the period while stopped. The bench checks that this first step lands on zero and raises exactly one pulse.

// File: rtl/mpt_pkg.sv
// Shared definitions for the prescaled master period timer.
// Assumes: register select is a single bit; prescaler codes are unsigned.
package mpt_pkg;

    // Register select encoding on the bus
    typedef enum logic {
        SEL_COUNT  = 1'b0,
        SEL_PERIOD = 1'b1
    } mpt_sel_e;

    // Number of insignificant low counter bits for a prescaler code
    function automatic int low_bits(input int code, input int fine_limit);
        return (code < fine_limit) ? (fine_limit - code) : 0;
    endfunction

    // Clock-division exponent for coarse prescaler codes
    function automatic int div_exp(input int code, input int fine_limit);
        return (code > fine_limit) ? (code - fine_limit) : 0;
    endfunction

endpackage

// File: rtl/mpt_prescaler.sv
// Step generator. It produces a step enable and the count of insignificant
// low bits for the current prescaler code. Fine codes step on every clock.
// Coarse codes step once per 2^(code-FINE_LIMIT) clocks.
// Assumes: FINE_LIMIT < 2^PSC_W; the divider restarts whenever the timer stops.
module mpt_prescaler #(
    parameter int PSC_W      = 3,
    parameter int FINE_LIMIT = 5,
    parameter int SW         = $clog2(FINE_LIMIT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic [PSC_W-1:0] psc_code,
    output logic             tick,
    output logic [SW-1:0]    fine_bits
);
    import mpt_pkg::*;

    localparam int MAX_CODE = (1 << PSC_W) - 1;
    localparam int DIV_MAX  = MAX_CODE - FINE_LIMIT;
    localparam int DW       = (DIV_MAX > 0) ? DIV_MAX : 1;

    logic [DW-1:0] div_cnt;
    logic [DW-1:0] div_last;

    // Decode the prescaler code into the divider end value and the low-bit count
    always_comb begin
        div_last  = DW'((1 << div_exp(int'(psc_code), FINE_LIMIT)) - 1);
        fine_bits = SW'(low_bits(int'(psc_code), FINE_LIMIT));
    end

    assign tick = run_en && (div_cnt == div_last);

    // Divider counter: restarts while stopped and after each step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_cnt <= '0;
        end else if (!run_en || tick) begin
            div_cnt <= '0;
        end else begin
            div_cnt <= div_cnt + DW'(1);
        end
    end

endmodule

// File: rtl/mpt_period_reg.sv
// Period register. A write is clamped into the window from the minimum to
// PER_MAX. The minimum is MIN_TICKS steps of the current step size.
// Assumes: MIN_TICKS << FINE_LIMIT fits in CNT_W bits.
module mpt_period_reg #(
    parameter int              CNT_W     = 16,
    parameter int              SW        = 3,
    parameter int              MIN_TICKS = 3,
    parameter logic [CNT_W-1:0] PER_MAX  = 16'hFFDF,
    parameter logic [CNT_W-1:0] PER_RST  = 16'hFFDF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wdata,
    input  logic [SW-1:0]    fine_bits,
    output logic [CNT_W-1:0] per_q
);
    logic [CNT_W-1:0] min_val;
    logic [CNT_W-1:0] clamped;

    // Clamp the written value into the legal window
    always_comb begin
        min_val = CNT_W'(MIN_TICKS) << fine_bits;
        if (wdata > PER_MAX) begin
            clamped = PER_MAX;
        end else if (wdata < min_val) begin
            clamped = min_val;
        end else begin
            clamped = wdata;
        end
    end

    // Store the clamped period on a write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            per_q <= PER_RST;
        end else if (wr_en) begin
            per_q <= clamped;
        end
    end

endmodule

// File: rtl/mpt_counter.sv
// Up-counter with period wrap. On each step it adds 2^fine_bits. When the sum
// would exceed the period it loads zero and flags a wrap for one cycle.
// Writes load the masked data only while stopped.
// Assumes: the step enable is low whenever run_en is low.
module mpt_counter #(
    parameter int CNT_W = 16,
    parameter int SW    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic             tick,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wdata,
    input  logic [SW-1:0]    fine_bits,
    input  logic [CNT_W-1:0] per,
    output logic [CNT_W-1:0] cnt_q,
    output logic             wrap_q
);
    logic [CNT_W:0]   step;
    logic [CNT_W:0]   sum;
    logic [CNT_W-1:0] keep_mask;
    logic             past_per;

    // Step size, next value, wrap decision and write mask
    always_comb begin
        step      = (CNT_W+1)'(1) << fine_bits;
        sum       = {1'b0, cnt_q} + step;
        past_per  = sum > {1'b0, per};
        keep_mask = ~((CNT_W'(1) << fine_bits) - CNT_W'(1));
    end

    // Count, wrap, or take a write while stopped
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            wrap_q <= 1'b0;
        end else begin
            wrap_q <= 1'b0;
            if (tick) begin
                if (past_per) begin
                    cnt_q  <= '0;
                    wrap_q <= 1'b1;
                end else begin
                    cnt_q <= sum[CNT_W-1:0];
                end
            end else if (!run_en && wr_en) begin
                cnt_q <= wdata & keep_mask;
            end
        end
    end

endmodule

// File: rtl/mpt_master_timer.sv
// Top of the prescaled master period timer. It joins the step generator,
// the period register and the counter behind a two-register bus with
// unclocked read data.
// Assumes: BUS_W >= CNT_W; bus_sel 0 selects the counter, 1 the period.
module mpt_master_timer #(
    parameter int              CNT_W      = 16,
    parameter int              BUS_W      = 32,
    parameter int              PSC_W      = 3,
    parameter int              FINE_LIMIT = 5,
    parameter int              MIN_TICKS  = 3,
    parameter logic [CNT_W-1:0] PER_MAX   = 16'hFFDF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic [PSC_W-1:0] psc_code,
    input  logic             bus_wr,
    input  logic             bus_sel,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata,
    output logic             wrap_pulse
);
    import mpt_pkg::*;

    localparam int SW = $clog2(FINE_LIMIT + 1);

    logic             tick;
    logic [SW-1:0]    fine_bits;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] per_q;
    logic [CNT_W-1:0] rd_mask;
    logic             cnt_wr;
    logic             per_wr;
    mpt_sel_e         sel;

    assign sel    = mpt_sel_e'(bus_sel);
    assign cnt_wr = bus_wr && (sel == SEL_COUNT);
    assign per_wr = bus_wr && (sel == SEL_PERIOD);

    generate
        if (BUS_W > CNT_W) begin : g_hi
            logic unused_wdata_hi;
            assign unused_wdata_hi = ^bus_wdata[BUS_W-1:CNT_W];
        end
    endgenerate

    mpt_prescaler #(
        .PSC_W      (PSC_W),
        .FINE_LIMIT (FINE_LIMIT),
        .SW         (SW)
    ) u_psc (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_en    (run_en),
        .psc_code  (psc_code),
        .tick      (tick),
        .fine_bits (fine_bits)
    );

    mpt_period_reg #(
        .CNT_W     (CNT_W),
        .SW        (SW),
        .MIN_TICKS (MIN_TICKS),
        .PER_MAX   (PER_MAX),
        .PER_RST   (PER_MAX)
    ) u_per (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (per_wr),
        .wdata     (bus_wdata[CNT_W-1:0]),
        .fine_bits (fine_bits),
        .per_q     (per_q)
    );

    mpt_counter #(
        .CNT_W (CNT_W),
        .SW    (SW)
    ) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_en    (run_en),
        .tick      (tick),
        .wr_en     (cnt_wr),
        .wdata     (bus_wdata[CNT_W-1:0]),
        .fine_bits (fine_bits),
        .per       (per_q),
        .cnt_q     (cnt_q),
        .wrap_q    (wrap_pulse)
    );

    // Read mux: counter shown with its insignificant bits forced low
    always_comb begin
        rd_mask = ~((CNT_W'(1) << fine_bits) - CNT_W'(1));
        if (sel == SEL_PERIOD) begin
            bus_rdata = BUS_W'(per_q);
        end else begin
            bus_rdata = BUS_W'(cnt_q & rd_mask);
        end
    end

endmodule

// File: rtl/mpt_master_timer_chk.sv
// Property checker for the prescaled master period timer, bound to the top.
// Assumes: connected to the top's counter and period state.
module mpt_master_timer_chk #(
    parameter int              CNT_W     = 16,
    parameter int              MIN_TICKS = 3,
    parameter logic [CNT_W-1:0] PER_MAX  = 16'hFFDF
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run_en,
    input logic             bus_wr,
    input logic             bus_sel,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] per,
    input logic             wrap_pulse
);
    AST_STOPPED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && !(bus_wr && !bus_sel)) |=> $stable(cnt)); // R11
    AST_NO_PULSE_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> !wrap_pulse); // R11
    AST_WRAP_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_pulse |-> (cnt == '0)); // R7
    AST_PER_CEILING: assert property (@(posedge clk) disable iff (!rst_n)
        per <= PER_MAX); // R8
    AST_PER_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        per >= CNT_W'(MIN_TICKS)); // R9
    AST_PER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_sel) |=> $stable(per)); // R8
endmodule

bind mpt_master_timer mpt_master_timer_chk #(
    .CNT_W     (CNT_W),
    .MIN_TICKS (MIN_TICKS),
    .PER_MAX   (PER_MAX)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_en     (run_en),
    .bus_wr     (bus_wr),
    .bus_sel    (bus_sel),
    .cnt        (cnt_q),
    .per        (per_q),
    .wrap_pulse (wrap_pulse)
);

// File: tb/mpt_master_timer_bench.sv
// Self-checking bench: a vector table walked by one loop, then directed tests.
module mpt_master_timer_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run_en = 1'b0;
    logic [2:0]  psc_code = 3'd0;
    logic        bus_wr = 1'b0;
    logic        bus_sel = 1'b0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic        wrap_pulse;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    mpt_master_timer u_mpt_master_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_en     (run_en),
        .psc_code   (psc_code),
        .bus_wr     (bus_wr),
        .bus_sel    (bus_sel),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .wrap_pulse (wrap_pulse)
    );

    typedef struct packed {
        logic [2:0]  code;
        logic [15:0] per_wr;
        logic [15:0] cnt_wr;
        logic [7:0]  nclk;
        logic [15:0] exp_per;
        logic [15:0] exp_cnt;
        logic [3:0]  exp_pulses;
    } vec_t;

    localparam vec_t VEC [10] = '{
        {3'd0, 16'h0100, 16'h0000, 8'd5, 16'h0100, 16'h00A0, 4'd0},
        {3'd0, 16'h0060, 16'h0000, 8'd5, 16'h0060, 16'h0020, 4'd1},
        {3'd2, 16'h0020, 16'h0010, 8'd4, 16'h0020, 16'h0008, 4'd1},
        {3'd4, 16'h0010, 16'h000E, 8'd3, 16'h0010, 16'h0002, 4'd1},
        {3'd5, 16'h0005, 16'h0003, 8'd6, 16'h0005, 16'h0003, 4'd1},
        {3'd7, 16'h0100, 16'h0010, 8'd9, 16'h0100, 16'h0012, 4'd0},
        {3'd6, 16'h0004, 16'h0003, 8'd6, 16'h0004, 16'h0001, 4'd1},
        {3'd1, 16'h0040, 16'h001F, 8'd4, 16'h0040, 16'h0000, 4'd1},
        {3'd3, 16'h0008, 16'h0000, 8'd4, 16'h000C, 16'h0000, 4'd1},
        {3'd5, 16'h0010, 16'h0020, 8'd1, 16'h0010, 16'h0000, 4'd1}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic sel, input logic [31:0] data);
        @(negedge clk);
        bus_wr    = 1'b1;
        bus_sel   = sel;
        bus_wdata = data;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic bus_read(input logic sel, output logic [31:0] data);
        @(negedge clk);
        bus_sel = sel;
        #1 data = bus_rdata;
    endtask

    // Run for n enabled edges; count pulses, check counter is zero on each pulse
    task automatic run_for(input int n, output int pulses);
        pulses = 0;
        @(negedge clk);
        bus_sel = 1'b0;
        run_en  = 1'b1;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (wrap_pulse) begin
                pulses++;
                check("R7 counter zero during pulse", bus_rdata, 32'd0);
            end
        end
        run_en = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        int          np;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        bus_read(1'b0, rd);
        check("R1 counter reset", rd, 32'h0000_0000);
        bus_read(1'b1, rd);
        check("R1 period reset", rd, 32'h0000_FFDF);
        check("R1 pulse reset", {31'd0, wrap_pulse}, 32'd0);

        // Vector table: R4 R5 R6 R7 R9 R10
        foreach (VEC[k]) begin
            logic [15:0] keep;
            @(negedge clk);
            psc_code = VEC[k].code;
            bus_write(1'b1, {16'd0, VEC[k].per_wr});
            bus_write(1'b0, {16'd0, VEC[k].cnt_wr});
            bus_read(1'b1, rd);
            check($sformatf("R9 vector %0d period", k), rd, {16'd0, VEC[k].exp_per});
            keep = (VEC[k].code < 3'd5) ? ~((16'd1 << (5 - VEC[k].code)) - 16'd1) : 16'hFFFF;
            bus_read(1'b0, rd);
            check($sformatf("R4 vector %0d counter load", k), rd, {16'd0, VEC[k].cnt_wr & keep});
            run_for(int'(VEC[k].nclk), np);
            bus_read(1'b0, rd);
            check($sformatf("R5 R6 R10 vector %0d final count", k), rd, {16'd0, VEC[k].exp_cnt});
            check($sformatf("R7 vector %0d pulse count", k), np, {28'd0, VEC[k].exp_pulses});
        end

        // R2 upper write bits ignored, upper read bits zero
        psc_code = 3'd5;
        bus_write(1'b1, 32'h1234_0100);
        bus_read(1'b1, rd);
        check("R2 period upper bits", rd, 32'h0000_0100);
        bus_write(1'b0, 32'hABCD_0040);
        bus_read(1'b0, rd);
        check("R2 counter upper bits", rd, 32'h0000_0040);

        // R4 masking at code 2: three low bits
        psc_code = 3'd2;
        bus_write(1'b0, 32'h0000_00FF);
        bus_read(1'b0, rd);
        check("R4 code2 low bits", rd, 32'h0000_00F8);

        // R3 write during run ignored, step on the same edge still taken
        psc_code = 3'd5;
        bus_write(1'b0, 32'h0000_0010);
        @(negedge clk);
        bus_sel = 1'b0;
        run_en  = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b1;
        bus_wdata = 32'h0000_0080;
        @(negedge clk);
        bus_wr = 1'b0;
        run_en = 1'b0;
        bus_read(1'b0, rd);
        check("R3 write while running", rd, 32'h0000_0012);

        // R11 hold while stopped
        repeat (5) begin
            @(negedge clk);
            check("R11 no pulse stopped", {31'd0, wrap_pulse}, 32'd0);
        end
        bus_read(1'b0, rd);
        check("R11 counter held", rd, 32'h0000_0012);

        // R8 ceiling
        bus_write(1'b1, 32'h0000_FFFF);
        bus_read(1'b1, rd);
        check("R8 clamp FFFF", rd, 32'h0000_FFDF);
        bus_write(1'b1, 32'h0000_FFE0);
        bus_read(1'b1, rd);
        check("R8 clamp FFE0", rd, 32'h0000_FFDF);
        bus_write(1'b1, 32'h0000_FFDF);
        bus_read(1'b1, rd);
        check("R8 exact max", rd, 32'h0000_FFDF);

        // R9 floor per code
        psc_code = 3'd0;
        bus_write(1'b1, 32'h0000_0010);
        bus_read(1'b1, rd);
        check("R9 code0 floor", rd, 32'h0000_0060);
        psc_code = 3'd4;
        bus_write(1'b1, 32'h0000_0001);
        bus_read(1'b1, rd);
        check("R9 code4 floor", rd, 32'h0000_0006);
        psc_code = 3'd7;
        bus_write(1'b1, 32'h0000_0000);
        bus_read(1'b1, rd);
        check("R9 code7 floor", rd, 32'h0000_0003);

        // R1 reset again from a non-reset state
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        bus_read(1'b1, rd);
        check("R1 period after second reset", rd, 32'h0000_FFDF);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule